// File: doc/BRIEF.md
# Serial-Controlled Clock Fanout Gate

This block is the digital core of a one-in, many-out clock distribution buffer. A single reference clock feeds six output pairs and one feedback output. Each pair has a primary output and a secondary output. A static mode strap selects what the secondary output carries. In differential mode it carries the inverted reference. In copy mode it carries a second in-phase copy.

A host switches individual outputs on and off over a two-wire serial write interface. The slave answers one fixed device address. It treats the first data byte as a command code and the second as a byte count. Every byte after those two is loaded into register slot 0, 1, 2 and so on. Only slots 6 and 7 hold enable bits; their other bits are reserved.

The serial lines are sampled and synchronized in the reference clock domain. Enable changes are retimed so that a gated output only switches on or off while it is low. An active-low power-down input overrides everything and holds all outputs low.

Top module: `clk_fanout_ctl`

## Requirements
- R1: The slave acknowledges (drives `sda_oe` high during the ninth clock) only an address byte equal to 1101001 followed by a write bit of 0 (byte 0xD2). Any other address, or a read bit of 1, is not acknowledged, and the transaction changes no output.
- R2: Every data byte of an addressed write is acknowledged. Data bits are taken most-significant first. Data byte 0 is a command code and data byte 1 is a byte count; neither is stored. Data byte k (k >= 2) is written to register slot k-2.
- R3: Slot 7 enables pair 0 with bit 0, pair 1 with bit 2, pair 2 with bit 5 and pair 3 with bit 6.
- R4: Slot 6 enables pair 4 with bit 1, pair 5 with bit 3 and the feedback output with bit 4.
- R5: Reserved bits have no effect on any output. These are slot 7 bits 1, 3, 4 and 7, slot 6 bits 0, 2, 5, 6 and 7, and all bits of slots 0 to 5.
- R6: After reset every pair and the feedback output are enabled, which corresponds to slot 7 = 0xFF and slot 6 = 0x1F.
- R7: While `pwr_dn_n` is 0, every pair output and `fb_o` are 0, whatever the enable state.
- R8: With `ddr_mode` = 1 an enabled pair drives the reference on `pair_t` and its inverse on `pair_c`. With `ddr_mode` = 0 both drive the reference. `fb_o` always follows the reference when enabled.
- R9: A disabled pair holds both of its outputs at 0.
- R10: The enable of a primary output changes only at a falling reference edge. The enable of a complement output changes only at the following rising edge. No output produces a shortened pulse.
- R11: A STOP returns the slave to idle. A repeated START begins a new address phase whatever the slave was doing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Reference clock, the source of all outputs and the sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Serial clock line |
| sda_in | input | 1 | Serial data line as seen on the bus |
| sda_oe | output | 1 | Pull the data line low (acknowledge) |
| ddr_mode | input | 1 | 1: complement outputs inverted, 0: in-phase copies |
| pwr_dn_n | input | 1 | Active-low power-down, forces all outputs low |
| pair_t | output | 6 | Primary output of each pair |
| pair_c | output | 6 | Secondary output of each pair |
| fb_o | output | 1 | Feedback clock output |

## Verification
The enable map is driven with patterns that each light a different, non-overlapping subset of pairs, so a swapped or shifted bit position shows up as a wrong pair running. One pattern sets only reserved bits and must switch every output off. Foreign addresses, a read bit and a NACKed address followed by a repeated START separate address decoding from framing. Power-down and mode changes are applied over varied enable states, and both clock phases are compared, so that inversion, copying and forcing low can be told apart from one another.

// File: rtl/clkfan_pkg.sv
package clkfan_pkg;

  localparam int unsigned NPAIR   = 6;
  localparam int unsigned NGATE   = NPAIR + 1;   // pairs plus feedback
  localparam int unsigned SLOT_W  = 5;
  localparam int unsigned FB_IDX  = NPAIR;

  typedef enum logic [2:0] {
    SL_IDLE,
    SL_ADDR,
    SL_AACK,
    SL_DATA,
    SL_DACK
  } sl_state_e;

  // register slot that holds the enable of gate i
  function automatic int unsigned gate_slot(int unsigned i);
    return (i < 4) ? 7 : 6;
  endfunction

  // bit position inside that slot
  function automatic int unsigned gate_bit(int unsigned i);
    case (i)
      0:       return 0;
      1:       return 2;
      2:       return 5;
      3:       return 6;
      4:       return 1;
      5:       return 3;
      default: return 4;
    endcase
  endfunction

endpackage

// File: rtl/clkfan_serial_rx.sv
module clkfan_serial_rx
  import clkfan_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'b1101001,
  parameter int unsigned IDX_W   = SLOT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_in,
  input  logic             sda_in,
  output logic             sda_oe,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic [7:0]       wr_data
);

  localparam logic [IDX_W-1:0] HDR_BYTES = IDX_W'(2);
  localparam logic [IDX_W-1:0] IDX_MAX   = '1;

  // line synchronizers with one extra stage for edge detection
  logic [2:0] scl_sh, sda_sh;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= 3'b111;
      sda_sh <= 3'b111;
    end else begin
      scl_sh <= {scl_sh[1:0], scl_in};
      sda_sh <= {sda_sh[1:0], sda_in};
    end
  end

  logic scl_s, sda_s, scl_p, sda_p;
  assign scl_s = scl_sh[1];
  assign sda_s = sda_sh[1];
  assign scl_p = scl_sh[2];
  assign sda_p = sda_sh[2];

  logic scl_rise, scl_fall, start_c, stop_c;
  assign scl_rise = scl_s & ~scl_p;
  assign scl_fall = ~scl_s & scl_p;
  assign start_c  = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_c   = scl_s & scl_p & ~sda_p & sda_s;

  sl_state_e        state_q, state_n;
  logic [3:0]       cnt_q, cnt_n;
  logic [7:0]       sh_q, sh_n;
  logic             oe_q, oe_n;
  logic [IDX_W-1:0] bidx_q, bidx_n;
  logic             wr_c;

  always_comb begin
    state_n = state_q;
    cnt_n   = cnt_q;
    sh_n    = sh_q;
    oe_n    = oe_q;
    bidx_n  = bidx_q;
    wr_c    = 1'b0;
    if (stop_c) begin
      state_n = SL_IDLE;
      oe_n    = 1'b0;
    end else if (start_c) begin
      state_n = SL_ADDR;
      cnt_n   = 4'd0;
      bidx_n  = '0;
      oe_n    = 1'b0;
    end else begin
      case (state_q)
        SL_ADDR, SL_DATA: begin
          if (scl_rise && cnt_q != 4'd8) begin
            sh_n  = {sh_q[6:0], sda_s};
            cnt_n = cnt_q + 4'd1;
          end else if (scl_fall && cnt_q == 4'd8) begin
            if (state_q == SL_ADDR) begin
              if (sh_q[7:1] == DEV_ADDR && !sh_q[0]) begin
                state_n = SL_AACK;
                oe_n    = 1'b1;
              end else begin
                state_n = SL_IDLE;
              end
            end else begin
              state_n = SL_DACK;
              oe_n    = 1'b1;
              wr_c    = (bidx_q >= HDR_BYTES);
              bidx_n  = (bidx_q == IDX_MAX) ? bidx_q : bidx_q + 1'b1;
            end
          end
        end
        SL_AACK, SL_DACK: begin
          if (scl_fall) begin
            state_n = SL_DATA;
            oe_n    = 1'b0;
            cnt_n   = 4'd0;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SL_IDLE;
      cnt_q   <= 4'd0;
      sh_q    <= 8'd0;
      oe_q    <= 1'b0;
      bidx_q  <= '0;
    end else begin
      state_q <= state_n;
      cnt_q   <= cnt_n;
      sh_q    <= sh_n;
      oe_q    <= oe_n;
      bidx_q  <= bidx_n;
    end
  end

  assign sda_oe  = oe_q;
  assign wr_en   = wr_c;
  assign wr_idx  = bidx_q - HDR_BYTES;
  assign wr_data = sh_q;

  assert_nack_foreign_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SL_ADDR && scl_fall && cnt_q == 4'd8 && !start_c && !stop_c &&
     (sh_q[7:1] != DEV_ADDR || sh_q[0])) |=> (state_q == SL_IDLE && !sda_oe));

  assert_ack_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SL_DATA && scl_fall && cnt_q == 4'd8 && !start_c && !stop_c) |=> sda_oe);

  assert_oe_in_ack_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe |-> (state_q == SL_AACK || state_q == SL_DACK));

  assert_stop_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    stop_c |=> (state_q == SL_IDLE && !sda_oe));

endmodule

// File: rtl/clkfan_enable_regs.sv
module clkfan_enable_regs
  import clkfan_pkg::*;
#(
  parameter int unsigned IDX_W = SLOT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [7:0]       wr_data,
  output logic [NGATE-1:0] en_o
);

  logic [NGATE-1:0] en_q, en_n;

  for (genvar g = 0; g < NGATE; g++) begin : g_map
    localparam logic [IDX_W-1:0] SLOT = IDX_W'(gate_slot(g));
    localparam int unsigned      BPOS = gate_bit(g);
    always_comb begin
      en_n[g] = en_q[g];
      if (wr_en && wr_idx == SLOT) en_n[g] = wr_data[BPOS];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '1;
    else        en_q <= en_n;
  end

  assign en_o = en_q;

  assert_en_needs_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q != $past(en_q)) |-> $past(wr_en));

endmodule

// File: rtl/clkfan_gate_cell.sv
module clkfan_gate_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic en_req,
  input  logic pd_n,
  input  logic ddr_mode,
  output logic true_o,
  output logic comp_o
);

  // primary enable moves while the reference is low
  logic en_lo_q;
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) en_lo_q <= 1'b1;
    else        en_lo_q <= en_req;
  end

  // inverted output enable moves while the inverted reference is low
  logic en_hi_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_hi_q <= 1'b1;
    else        en_hi_q <= en_lo_q;
  end

  logic t_g, c_inv, c_cpy;
  assign t_g    = clk & en_lo_q;
  assign c_inv  = ~clk & en_hi_q;
  assign c_cpy  = clk & en_lo_q;
  assign true_o = t_g & pd_n;
  assign comp_o = (ddr_mode ? c_inv : c_cpy) & pd_n;

  assert_gate_align_R10: assert property (@(negedge clk) disable iff (!rst_n)
    en_hi_q == en_lo_q);

  assert_diff_phase_R8: assert property (@(negedge clk) disable iff (!rst_n)
    (pd_n && ddr_mode && en_lo_q) |-> (true_o && !comp_o));

endmodule

// File: rtl/clk_fanout_ctl.sv
module clk_fanout_ctl
  import clkfan_pkg::*;
(
  input  logic             clk_ref,
  input  logic             rst_n,
  input  logic             scl_in,
  input  logic             sda_in,
  output logic             sda_oe,
  input  logic             ddr_mode,
  input  logic             pwr_dn_n,
  output logic [NPAIR-1:0] pair_t,
  output logic [NPAIR-1:0] pair_c,
  output logic             fb_o
);

  // reset: asserted asynchronously, released on the reference clock
  logic [1:0] rst_sync_q;
  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  logic rst_int_n;
  assign rst_int_n = rst_sync_q[1];

  logic              wr_en;
  logic [SLOT_W-1:0] wr_idx;
  logic [7:0]        wr_data;
  logic [NGATE-1:0]  en_vec;

  clkfan_serial_rx #(.IDX_W(SLOT_W)) u_rx (
    .clk     (clk_ref),
    .rst_n   (rst_int_n),
    .scl_in  (scl_in),
    .sda_in  (sda_in),
    .sda_oe  (sda_oe),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data (wr_data)
  );

  clkfan_enable_regs #(.IDX_W(SLOT_W)) u_regs (
    .clk     (clk_ref),
    .rst_n   (rst_int_n),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .en_o    (en_vec)
  );

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    clkfan_gate_cell u_cell (
      .clk      (clk_ref),
      .rst_n    (rst_int_n),
      .en_req   (en_vec[p]),
      .pd_n     (pwr_dn_n),
      .ddr_mode (ddr_mode),
      .true_o   (pair_t[p]),
      .comp_o   (pair_c[p])
    );
  end

  // feedback output: single-ended, gated on the falling edge
  logic fb_en_q;
  always_ff @(negedge clk_ref or negedge rst_int_n) begin
    if (!rst_int_n) fb_en_q <= 1'b1;
    else            fb_en_q <= en_vec[FB_IDX];
  end
  assign fb_o = clk_ref & fb_en_q & pwr_dn_n;

  assert_pd_low_hi_R7: assert property (@(negedge clk_ref) disable iff (!rst_int_n)
    !pwr_dn_n |-> (pair_t == '0 && pair_c == '0 && !fb_o));

  assert_pd_low_lo_R7: assert property (@(posedge clk_ref) disable iff (!rst_int_n)
    !pwr_dn_n |-> (pair_t == '0 && pair_c == '0 && !fb_o));

  assert_off_pair_low_R9: assert property (@(negedge clk_ref) disable iff (!rst_int_n)
    (en_vec[0] == 1'b0 && $past(en_vec[0]) == 1'b0) |-> (!pair_t[0] && !pair_c[0]));

endmodule

// File: tb/sim_clk_fanout_ctl.sv
`timescale 1ns/1ps
module sim_clk_fanout_ctl;

  localparam int Q = 4;   // clocks per quarter serial bit

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_h = 1'b1, sda_h = 1'b1;
  logic       ddr_mode = 1'b1, pwr_dn_n = 1'b1;
  logic       sda_oe, fb_o;
  logic [5:0] pair_t, pair_c;

  always #4 clk = ~clk;   // 125 MHz

  clk_fanout_ctl u0 (
    .clk_ref (clk), .rst_n (rst_n), .scl_in (scl_h), .sda_in (sda_h & ~sda_oe),
    .sda_oe (sda_oe), .ddr_mode (ddr_mode), .pwr_dn_n (pwr_dn_n),
    .pair_t (pair_t), .pair_c (pair_c), .fb_o (fb_o)
  );

  int         n_cmp = 0, n_bad = 0;
  logic [6:0] exp_en = 7'h7F;   // [5:0] pairs, [6] feedback
  bit         chk_on = 0, busy = 0;
  string      tag = "R6";
  byte unsigned tx_q[$];

  task automatic check(input string t, input logic act, input logic exp, input string what);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s act=%b exp=%b t=%0t", t, what, act, exp, $time);
    end
  endtask

  task automatic cmp_phase(input bit hi);
    for (int i = 0; i < 6; i++) begin
      logic e, et, ec;
      e  = exp_en[i] & pwr_dn_n;
      et = hi ? e : 1'b0;
      ec = ddr_mode ? (hi ? 1'b0 : e) : et;
      check(tag, pair_t[i], et, $sformatf("pair_t[%0d]", i));
      check(tag, pair_c[i], ec, $sformatf("pair_c[%0d]", i));
    end
    check(tag, fb_o, hi ? (exp_en[6] & pwr_dn_n) : 1'b0, "fb_o");
  endtask

  always @(posedge clk) if (chk_on && !busy) begin #2; if (!busy) cmp_phase(1); end
  always @(negedge clk) if (chk_on && !busy) begin #2; if (!busy) cmp_phase(0); end

  task automatic wclk(input int n); repeat (n) @(posedge clk); endtask

  task automatic send_bit(input logic b);
    sda_h = b; wclk(Q); scl_h = 1; wclk(2*Q); scl_h = 0; wclk(Q);
  endtask

  task automatic get_ack(input logic exp, input string t);
    sda_h = 1; wclk(Q); scl_h = 1; wclk(Q);
    #2 check(t, sda_oe, exp, "ack");
    wclk(Q); scl_h = 0; wclk(Q);
  endtask

  task automatic send_byte(input byte unsigned v, input logic exp_ack, input string t);
    for (int k = 7; k >= 0; k--) send_bit(v[k]);
    get_ack(exp_ack, t);
  endtask

  function automatic void model_store(input int slot, input byte unsigned v);
    if (slot == 7) begin
      exp_en[0] = v[0]; exp_en[1] = v[2]; exp_en[2] = v[5]; exp_en[3] = v[6];
    end else if (slot == 6) begin
      exp_en[4] = v[1]; exp_en[5] = v[3]; exp_en[6] = v[4];
    end
  endfunction

  // one write transaction; tx_q holds cmd, count and slot bytes
  task automatic txn(input byte unsigned abyte, input bit exp_ack, input bit rep,
                     input bit do_stop, input string t);
    busy = 1;
    if (rep) begin
      sda_h = 1; wclk(Q); scl_h = 1; wclk(2*Q); sda_h = 0; wclk(2*Q); scl_h = 0; wclk(Q);
    end else begin
      sda_h = 0; wclk(2*Q); scl_h = 0; wclk(Q);
    end
    send_byte(abyte, exp_ack, t);
    if (exp_ack)
      foreach (tx_q[i]) send_byte(tx_q[i], 1'b1, "R2");
    if (do_stop) begin
      sda_h = 0; wclk(Q); scl_h = 1; wclk(2*Q); sda_h = 1; wclk(2*Q);
    end
    if (exp_ack) foreach (tx_q[i]) if (i >= 2) model_store(i - 2, tx_q[i]);
    if (do_stop) begin wclk(8); busy = 0; end
  endtask

  task automatic load_slots(input byte unsigned s6, input byte unsigned s7);
    tx_q = {8'h00, 8'h08, 8'hAA, 8'h55, 8'hFF, 8'hFF, 8'hFF, 8'hFF, s6, s7};
  endtask

  initial begin : watchdog
    wclk(150000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : stim
    wclk(3); #1 rst_n = 1;
    wclk(4);
    chk_on = 1;
    tag = "R6"; wclk(40);                    // all enabled after reset

    tag = "R3"; load_slots(8'h00, 8'h01);    // only pair0, feedback off
    txn(8'hD2, 1, 0, 1, "R1"); wclk(30);
    tag = "R4"; load_slots(8'h08, 8'h64);    // pair5, pairs1..3
    txn(8'hD2, 1, 0, 1, "R1"); wclk(30);
    tag = "R4"; load_slots(8'h12, 8'h00);    // pair4 and feedback
    txn(8'hD2, 1, 0, 1, "R1"); wclk(30);

    tag = "R5"; load_slots(8'hE5, 8'h9A);    // reserved bits only: all off
    txn(8'hD2, 1, 0, 1, "R1"); wclk(30);

    tag = "R1"; load_slots(8'hFF, 8'hFF);    // foreign address, read bit
    txn(8'hD4, 0, 0, 1, "R1"); wclk(30);
    txn(8'hD3, 0, 0, 1, "R1"); wclk(30);

    tag = "R11"; load_slots(8'h1A, 8'h41);   // NACK then repeated START
    txn(8'hA6, 0, 0, 0, "R11");
    txn(8'hD2, 1, 1, 1, "R11"); wclk(30);

    tag = "R9"; wclk(30);                    // partly disabled pairs stay low
    tag = "R8"; @(posedge clk); #1 ddr_mode = 0; wclk(30);
    tag = "R7"; @(posedge clk); #1 pwr_dn_n = 0; wclk(30);
    @(posedge clk); #1 ddr_mode = 1; wclk(20);
    tag = "R2"; load_slots(8'hFF, 8'hFF);    // all on, still powered down
    txn(8'hD2, 1, 0, 1, "R2"); wclk(20);
    tag = "R7"; @(posedge clk); #1 pwr_dn_n = 1; wclk(30);
    tag = "R10"; load_slots(8'h00, 8'h00);   // everything off
    txn(8'hD2, 1, 0, 1, "R10"); wclk(30);

    chk_on = 0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule